// File: doc/BRIEF.md
# Mailbox Flash-Update Command Sequencer

This block is a host-side state machine that asks a security co-processor, through its mailbox, to update the flash image. It talks to the mailbox over a simple master port. The port issues one single-cycle register write or register read at a time, and each read is answered later by a read-valid pulse. The mailbox has three registers. The command/status register carries a ready flag in bit 31, a command code in bits 23:16 and a completion status in bits 15:0. The data register carries one 32-bit word. A write of 1 to the doorbell register tells the co-processor that a command is waiting.

After a start pulse the sequencer first waits for the mailbox to report ready. It then passes the 64-bit image address in two halves, one handshaked command per half, and finally issues the flash-update command. Every command is followed by a poll of the ready flag and a check of the 16-bit status. The first failure ends the run. The outcome is reported as done, status error or timeout. On a failure the failing command code and the status are held on the outputs until the next start. Each poll loop has a cycle budget that comes from an input port.

Top module: `mbox_flash_seq`

## Requirements
- R1: After reset the sequencer is idle. busy, done, err_status, err_timeout and bus_req are 0, and fail_cmd and fail_status are zero.
- R2: After an accepted start, no write is issued until a read of the command/status register returns bit 31 = 1. If every response in the first poll loop shows bit 31 = 0 until the cycle budget is used, the run ends with err_timeout = 1, fail_cmd = 0x00, fail_status = 0 and no write issued.
- R3: Every write to the command/status register (address 0x00) carries the command code in bits 23:16, with bits 31:24 and 15:0 zero. The code is one of 0x02, 0x03 or 0x04.
- R4: Each command write is followed, in the very next bus cycle, by a write of the value 1 to the doorbell register (address 0x08).
- R5: After each doorbell the command/status register is polled until bit 31 = 1. If bit 31 is still 0 in a response that arrives once timeout_limit cycles have passed since the doorbell, the run ends with err_timeout = 1 and fail_cmd set to the pending command code.
- R6: When the ready response after a doorbell carries a nonzero value in bits 15:0, the run ends with err_status = 1, fail_cmd = that command's code and fail_status = the 16-bit value.
- R7: On success the writes come in this exact order: data (0x04) with address bits 31:0, command 0x00020000, doorbell 1, data with address bits 63:32, command 0x00030000, doorbell 1, command 0x00040000, doorbell 1. After that done = 1.
- R8: The first failure ends the run and no further bus transaction follows. At most one of done, err_status and err_timeout is 1.
- R9: At most one read is outstanding. No request is issued while a read has not yet been answered by bus_rvalid.
- R10: done, err_status, err_timeout, fail_cmd and fail_status hold their values while idle and are cleared in the cycle after an accepted start.
- R11: A ready response that arrives in the same cycle as the end of the cycle budget counts as success. Across a sweep of co-processor delays, each run ends in exactly one of done or timeout, and once a delay leads to a timeout, every longer delay does too.
- R12: A start pulse while busy = 1 is ignored. The ongoing run completes with the normal write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| image_addr | input | 64 | Flash image address, sampled during the run |
| timeout_limit | input | TW | Cycle budget for each poll loop |
| bus_req | output | 1 | Single-cycle transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read response valid |
| bus_rdata | input | 32 | Read response data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All three commands succeeded |
| err_status | output | 1 | A command returned a nonzero status |
| err_timeout | output | 1 | A poll loop ran out of budget |
| fail_cmd | output | 8 | Code of the failing command (0x00 for the initial ready wait) |
| fail_status | output | 16 | Status returned by the failing command (0 on timeout) |

## Verification
Two functions can meet in one cycle: a ready response from the mailbox can return in the same cycle that the poll timer reaches its budget. This is provoked by sweeping the mailbox model's doorbell-to-ready delay one cycle at a time across a fixed timeout_limit, at two read latencies. Each run must end in exactly one of done or err_timeout. Short delays must succeed, long delays must time out, and the outcome may change only once, from success to timeout.

// File: rtl/mbox_seq_pkg.sv
// Package: shared state encoding, mailbox field positions and command codes
// for the flash-update sequencer. Assumes a 32-bit mailbox data path.
package mbox_seq_pkg;

    localparam int READY_BIT = 31;
    localparam int CODE_LSB  = 16;
    localparam int CODE_W    = 8;
    localparam int STAT_W    = 16;
    localparam int DATA_W    = 32;

    localparam logic [CODE_W-1:0] CODE_NONE    = 8'h00;
    localparam logic [CODE_W-1:0] CODE_ADDR_LO = 8'h02;
    localparam logic [CODE_W-1:0] CODE_ADDR_HI = 8'h03;
    localparam logic [CODE_W-1:0] CODE_FLASH   = 8'h04;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RDY_RD,
        S_RDY_WT,
        S_DATA_WR,
        S_CMD_WR,
        S_BELL_WR,
        S_ACK_RD,
        S_ACK_WT
    } seq_state_t;

    typedef enum logic [1:0] {
        REG_CMD,
        REG_DATA,
        REG_BELL
    } reg_sel_t;

    typedef struct packed {
        logic              issue;
        logic              we;
        reg_sel_t          sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

endpackage

// File: rtl/mbox_bus_port.sv
// Bus port: registers one transaction request per cycle onto the master port,
// tracks the single outstanding read and splits its response into fields.
// Assumes every read is answered by bus_rvalid, in the request cycle or later.
module mbox_bus_port
    import mbox_seq_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] ADDR_CMD  = 'h00,
    parameter logic [AW-1:0] ADDR_DATA = 'h04,
    parameter logic [AW-1:0] ADDR_BELL = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    output logic              rd_pending,
    output logic              rsp_valid,
    output logic              rsp_ready,
    output logic [STAT_W-1:0] rsp_status,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic [AW-1:0] addr_dec;
    logic          rdata_unused;

    // Map the register selector onto a bus address.
    always_comb begin
        case (op.sel)
            REG_CMD:  addr_dec = ADDR_CMD;
            REG_DATA: addr_dec = ADDR_DATA;
            REG_BELL: addr_dec = ADDR_BELL;
            default:  addr_dec = ADDR_CMD;
        endcase
    end

    // Register the request so every bus output comes straight from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            bus_req   <= op.issue;
            bus_we    <= op.issue & op.we;
            bus_addr  <= op.issue ? addr_dec : '0;
            bus_wdata <= (op.issue & op.we) ? op.wdata : '0;
        end
    end

    // Track the one read in flight until its response arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending <= 1'b0;
        end else if (op.issue && !op.we) begin
            rd_pending <= 1'b1;
        end else if (bus_rvalid) begin
            rd_pending <= 1'b0;
        end
    end

    assign rsp_valid    = bus_rvalid & rd_pending;
    assign rsp_ready    = bus_rdata[READY_BIT];
    assign rsp_status   = bus_rdata[STAT_W-1:0];
    assign rdata_unused = ^bus_rdata[READY_BIT-1:STAT_W];

endmodule

// File: rtl/mbox_poll_timer.sv
// Poll timer: counts cycles since the last clear and saturates at its top value.
// It reports expiry once the count reaches the programmed limit.
module mbox_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt;

    // Count elapsed cycles, restarting on clear and holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/mbox_fail_latch.sv
// Outcome latch: holds done, error flags, failing code and status from the end
// of a run until the next accepted start. Assumes at most one event per cycle.
module mbox_fail_latch
    import mbox_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_done,
    input  logic              ev_stat,
    input  logic              ev_tmo,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [STAT_W-1:0] ev_status,
    output logic              done,
    output logic              err_status,
    output logic              err_timeout,
    output logic [CODE_W-1:0] fail_cmd,
    output logic [STAT_W-1:0] fail_status
);

    // Capture the outcome of a run and keep it until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            done        <= 1'b0;
            err_status  <= 1'b0;
            err_timeout <= 1'b0;
            fail_cmd    <= '0;
            fail_status <= '0;
        end else if (ev_done) begin
            done <= 1'b1;
        end else if (ev_stat || ev_tmo) begin
            err_status  <= ev_stat;
            err_timeout <= ev_tmo;
            fail_cmd    <= ev_code;
            fail_status <= ev_status;
        end
    end

endmodule

// File: rtl/mbox_seq_fsm.sv
// Sequencer FSM: waits for the mailbox to be ready, then runs the low address,
// high address and flash commands. Each command is written, the doorbell rung
// and the ready flag polled. The first failure returns the FSM to idle.
// Assumes the bus port accepts one request per cycle.
module mbox_seq_fsm
    import mbox_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       image_addr,
    input  logic              rd_pending,
    input  logic              rsp_valid,
    input  logic              rsp_ready,
    input  logic [STAT_W-1:0] rsp_status,
    input  logic              expired,
    output bus_op_t           op,
    output logic              timer_clr,
    output logic              clear,
    output logic              busy,
    output logic              ev_done,
    output logic              ev_stat,
    output logic              ev_tmo,
    output logic [CODE_W-1:0] ev_code,
    output logic [STAT_W-1:0] ev_status
);

    localparam logic [1:0] STEP_LO = 2'd0;
    localparam logic [1:0] STEP_HI = 2'd1;
    localparam logic [1:0] STEP_FL = 2'd2;

    seq_state_t        state, state_nxt;
    logic [1:0]        step, step_nxt;
    logic [CODE_W-1:0] code;

    assign code  = CODE_ADDR_LO + {{(CODE_W-2){1'b0}}, step};
    assign busy  = (state != S_IDLE);
    assign clear = (state == S_IDLE) && start;

    // Hold the current state and the command step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= STEP_LO;
        end else begin
            state <= state_nxt;
            step  <= step_nxt;
        end
    end

    // Next state, bus request and outcome events.
    always_comb begin
        state_nxt = state;
        step_nxt  = step;
        op        = '0;
        timer_clr = 1'b0;
        ev_done   = 1'b0;
        ev_stat   = 1'b0;
        ev_tmo    = 1'b0;
        ev_code   = code;
        ev_status = '0;
        case (state)
            S_IDLE: begin
                if (start) begin
                    state_nxt = S_RDY_RD;
                    step_nxt  = STEP_LO;
                    timer_clr = 1'b1;
                end
            end
            S_RDY_RD: begin
                if (!rd_pending) begin
                    op.issue  = 1'b1;
                    op.sel    = REG_CMD;
                    state_nxt = S_RDY_WT;
                end
            end
            S_RDY_WT: begin
                if (rsp_valid) begin
                    if (rsp_ready) begin
                        state_nxt = S_DATA_WR;
                    end else if (expired) begin
                        ev_tmo    = 1'b1;
                        ev_code   = CODE_NONE;
                        state_nxt = S_IDLE;
                    end else begin
                        state_nxt = S_RDY_RD;
                    end
                end
            end
            S_DATA_WR: begin
                op.issue  = 1'b1;
                op.we     = 1'b1;
                op.sel    = REG_DATA;
                op.wdata  = (step == STEP_LO) ? image_addr[31:0] : image_addr[63:32];
                state_nxt = S_CMD_WR;
            end
            S_CMD_WR: begin
                op.issue  = 1'b1;
                op.we     = 1'b1;
                op.sel    = REG_CMD;
                op.wdata  = '0;
                op.wdata[CODE_LSB +: CODE_W] = code;
                state_nxt = S_BELL_WR;
            end
            S_BELL_WR: begin
                op.issue  = 1'b1;
                op.we     = 1'b1;
                op.sel    = REG_BELL;
                op.wdata  = 32'd1;
                timer_clr = 1'b1;
                state_nxt = S_ACK_RD;
            end
            S_ACK_RD: begin
                if (!rd_pending) begin
                    op.issue  = 1'b1;
                    op.sel    = REG_CMD;
                    state_nxt = S_ACK_WT;
                end
            end
            S_ACK_WT: begin
                if (rsp_valid) begin
                    if (rsp_ready) begin
                        if (rsp_status != '0) begin
                            ev_stat   = 1'b1;
                            ev_status = rsp_status;
                            state_nxt = S_IDLE;
                        end else if (step == STEP_FL) begin
                            ev_done   = 1'b1;
                            state_nxt = S_IDLE;
                        end else begin
                            step_nxt  = step + 1'b1;
                            state_nxt = (step == STEP_HI) ? S_CMD_WR : S_DATA_WR;
                        end
                    end else if (expired) begin
                        ev_tmo    = 1'b1;
                        state_nxt = S_IDLE;
                    end else begin
                        state_nxt = S_ACK_RD;
                    end
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/mbox_flash_seq.sv
// Top: mailbox flash-update command sequencer. Joins the FSM, bus port, poll
// timer and outcome latch. Assumes the mailbox answers every read it receives.
module mbox_flash_seq
    import mbox_seq_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            TW        = 16,
    parameter logic [AW-1:0] ADDR_CMD  = 'h00,
    parameter logic [AW-1:0] ADDR_DATA = 'h04,
    parameter logic [AW-1:0] ADDR_BELL = 'h08
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [63:0]   image_addr,
    input  logic [TW-1:0] timeout_limit,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_rvalid,
    input  logic [31:0]   bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          err_status,
    output logic          err_timeout,
    output logic [7:0]    fail_cmd,
    output logic [15:0]   fail_status
);

    bus_op_t           op;
    logic              rd_pending, rsp_valid, rsp_ready;
    logic [STAT_W-1:0] rsp_status;
    logic              expired, timer_clr, clear;
    logic              ev_done, ev_stat, ev_tmo;
    logic [CODE_W-1:0] ev_code;
    logic [STAT_W-1:0] ev_status;

    mbox_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .image_addr (image_addr),
        .rd_pending (rd_pending),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_status (rsp_status),
        .expired    (expired),
        .op         (op),
        .timer_clr  (timer_clr),
        .clear      (clear),
        .busy       (busy),
        .ev_done    (ev_done),
        .ev_stat    (ev_stat),
        .ev_tmo     (ev_tmo),
        .ev_code    (ev_code),
        .ev_status  (ev_status)
    );

    mbox_bus_port #(
        .AW        (AW),
        .ADDR_CMD  (ADDR_CMD),
        .ADDR_DATA (ADDR_DATA),
        .ADDR_BELL (ADDR_BELL)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .rd_pending (rd_pending),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_status (rsp_status),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

    mbox_poll_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timer_clr),
        .limit   (timeout_limit),
        .expired (expired)
    );

    mbox_fail_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .ev_done     (ev_done),
        .ev_stat     (ev_stat),
        .ev_tmo      (ev_tmo),
        .ev_code     (ev_code),
        .ev_status   (ev_status),
        .done        (done),
        .err_status  (err_status),
        .err_timeout (err_timeout),
        .fail_cmd    (fail_cmd),
        .fail_status (fail_status)
    );

endmodule

// File: rtl/mbox_flash_seq_chk.sv
// Checker: port-level properties of the sequencer, bound to the top module.
// Assumes read responses come only for issued reads.
module mbox_flash_seq_chk #(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] ADDR_CMD  = 'h00,
    parameter logic [AW-1:0] ADDR_BELL = 'h08
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_rvalid,
    input logic          busy,
    input logic          done,
    input logic          err_status,
    input logic          err_timeout,
    input logic [7:0]    fail_cmd,
    input logic [15:0]   fail_status
);

    logic outst;

    // Track a read seen on the port that has not yet been answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= 1'b0;
        end else if (bus_req && !bus_we) begin
            outst <= !bus_rvalid;
        end else if (bus_rvalid) begin
            outst <= 1'b0;
        end
    end

    AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !outst); // R9

    AST_CMD_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_CMD) |->
        (bus_wdata[31:24] == 8'h00 && bus_wdata[15:0] == 16'h0000 &&
         bus_wdata[23:16] >= 8'h02 && bus_wdata[23:16] <= 8'h04)); // R3

    AST_BELL_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_CMD) |=>
        (bus_req && bus_we && bus_addr == ADDR_BELL && bus_wdata == 32'd1)); // R4

    AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, err_status, err_timeout}) <= 1); // R8

    AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_status || err_timeout) |-> !bus_req); // R8

    AST_OUTCOME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fail_cmd) && $stable(fail_status) &&
                               $stable(done) && $stable(err_status) && $stable(err_timeout))); // R10

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (!done && !err_status && !err_timeout && fail_cmd == 8'h00)); // R10

endmodule

bind mbox_flash_seq mbox_flash_seq_chk #(
    .AW        (AW),
    .ADDR_CMD  (ADDR_CMD),
    .ADDR_BELL (ADDR_BELL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rvalid  (bus_rvalid),
    .busy        (busy),
    .done        (done),
    .err_status  (err_status),
    .err_timeout (err_timeout),
    .fail_cmd    (fail_cmd),
    .fail_status (fail_status)
);

// File: tb/mbox_flash_seq_bench.sv
module mbox_flash_seq_bench;

    localparam int AW = 8;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   image_addr = '0;
    logic [TW-1:0] timeout_limit = 16'd40;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_rvalid = 1'b0;
    logic [31:0]   bus_rdata = '0;
    logic          busy, done, err_status, err_timeout;
    logic [7:0]    fail_cmd;
    logic [15:0]   fail_status;

    int total = 0;
    int bad = 0;

    mbox_flash_seq #(.AW(AW), .TW(TW)) u_mbox_flash_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .image_addr(image_addr),
        .timeout_limit(timeout_limit), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err_status(err_status),
        .err_timeout(err_timeout), .fail_cmd(fail_cmd), .fail_status(fail_status)
    );

    always #5 clk = ~clk;

    // Mailbox model state
    bit          mb_ready = 1'b0;
    logic [7:0]  mb_cmd = '0;
    logic [15:0] mb_status = '0;
    bit          cnt_active = 1'b0;
    int          cd = 0;
    logic [15:0] cd_stat = '0;
    int          ack_delay = 0;
    bit          ack_never [3];
    logic [15:0] inj_stat [3];
    int          rd_lat = 0;
    bit          outst = 1'b0;
    int          lat_cd = 0;
    int          overlap_n = 0;
    int          rd_n = 0;
    logic [7:0]  log_a [32];
    logic [31:0] log_d [32];
    int          log_n = 0;
    bit          pre_phase = 1'b0;
    int          early_wr = 0;

    // Mailbox model, acting on the falling edge
    always @(negedge clk) begin
        bus_rvalid = 1'b0;
        if (cnt_active) begin
            if (cd == 0) begin
                mb_ready = 1'b1; mb_status = cd_stat; cnt_active = 1'b0; pre_phase = 1'b0;
            end else cd = cd - 1;
        end
        if (outst) begin
            if (lat_cd == 0) begin
                bus_rvalid = 1'b1; bus_rdata = {mb_ready, 7'd0, mb_cmd, mb_status}; outst = 1'b0;
            end else lat_cd = lat_cd - 1;
        end
        if (rst_n && bus_req) begin
            if (!bus_we) begin
                rd_n++;
                if (outst) overlap_n++;
                if (rd_lat == 0) begin
                    bus_rvalid = 1'b1; bus_rdata = {mb_ready, 7'd0, mb_cmd, mb_status};
                end else begin
                    outst = 1'b1; lat_cd = rd_lat - 1;
                end
            end else begin
                if (pre_phase) early_wr++;
                if (log_n < 32) begin log_a[log_n] = bus_addr; log_d[log_n] = bus_wdata; end
                log_n++;
                if (bus_addr == 8'h00) begin
                    mb_ready = 1'b0; mb_cmd = bus_wdata[23:16]; mb_status = '0; cnt_active = 1'b0;
                end else if (bus_addr == 8'h08 && bus_wdata == 32'd1) begin
                    if (mb_cmd >= 8'd2 && mb_cmd <= 8'd4 && !ack_never[int'(mb_cmd) - 2]) begin
                        cnt_active = 1'b1; cd = ack_delay; cd_stat = inj_stat[int'(mb_cmd) - 2];
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string rq, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, rq, what, act, exp);
    endtask

    // Configure the mailbox model between runs
    task automatic prep(input int pre_delay, input bit pre_never, input int ackd,
                        input int lat, input int limit);
        @(posedge clk); #1;
        mb_cmd = '0; mb_status = '0; log_n = 0; outst = 1'b0; early_wr = 0;
        ack_delay = ackd; rd_lat = lat; timeout_limit = limit[TW-1:0];
        for (int i = 0; i < 3; i++) begin ack_never[i] = 1'b0; inj_stat[i] = '0; end
        if (pre_never) begin
            mb_ready = 1'b0; pre_phase = 1'b1; cnt_active = 1'b0;
        end else if (pre_delay == 0) begin
            mb_ready = 1'b1; pre_phase = 1'b0; cnt_active = 1'b0;
        end else begin
            mb_ready = 1'b0; pre_phase = 1'b1; cnt_active = 1'b1; cd = pre_delay; cd_stat = '0;
        end
    endtask

    task automatic run(input logic [63:0] a, input int repulse);
        bit hung;
        @(negedge clk);
        image_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hung = 1'b1;
        for (int k = 0; k < 20000; k++) begin
            if (!busy) begin hung = 1'b0; break; end
            start = (k == repulse);
            @(negedge clk);
        end
        start = 1'b0;
        chk(!hung, "R8", "run ends", {63'd0, hung}, 64'd0);
    endtask

    function automatic logic [39:0] exp_entry(input int i, input logic [63:0] a);
        case (i)
            0: exp_entry = {8'h04, a[31:0]};
            1: exp_entry = {8'h00, 32'h0002_0000};
            2: exp_entry = {8'h08, 32'd1};
            3: exp_entry = {8'h04, a[63:32]};
            4: exp_entry = {8'h00, 32'h0003_0000};
            5: exp_entry = {8'h08, 32'd1};
            6: exp_entry = {8'h00, 32'h0004_0000};
            default: exp_entry = {8'h08, 32'd1};
        endcase
    endfunction

    task automatic check_log(input string rq, input logic [63:0] a, input int n);
        int mism;
        mism = 0;
        chk_eq(rq, "write count", log_n, n);
        for (int i = 0; i < n && i < log_n; i++)
            if ({log_a[i], log_d[i]} != exp_entry(i, a)) mism++;
        chk_eq(rq, "write sequence mismatches", mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] addrs [4];
        bit seen_tmo;
        addrs[0] = 64'h0000_0001_0000_0002;
        addrs[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        addrs[2] = 64'h8000_0000_0000_0001;
        addrs[3] = 64'h1234_5678_9ABC_DEF0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1", "outputs after reset",
               {busy, done, err_status, err_timeout, bus_req, fail_cmd, fail_status}, 0);

        // R7 R3 R4: success with several addresses and latencies
        for (int lat = 0; lat < 3; lat += 2)
            for (int ai = 0; ai < 4; ai++) begin
                prep(0, 1'b0, ai, lat, 40);
                run(addrs[ai], -1);
                chk_eq("R7", "done flags", {done, err_status, err_timeout}, 3'b100);
                check_log("R7", addrs[ai], 8);
            end

        // R6 R8: status failure at each step
        for (int lat = 0; lat < 3; lat += 2)
            for (int s = 0; s < 3; s++)
                for (int v = 0; v < 3; v++) begin
                    logic [15:0] st;
                    st = (v == 0) ? 16'h0001 : (v == 1) ? 16'h8000 : 16'hFFFF;
                    prep(0, 1'b0, 1, lat, 40);
                    inj_stat[s] = st;
                    run(addrs[3], -1);
                    chk_eq("R6", "flags", {done, err_status, err_timeout}, 3'b010);
                    chk_eq("R6", "fail_cmd", fail_cmd, s + 2);
                    chk_eq("R6", "fail_status", fail_status, st);
                    check_log("R8", addrs[3], (s == 2) ? 8 : 3 * (s + 1));
                end

        // R2: mailbox never ready at start
        prep(0, 1'b1, 0, 0, 20);
        run(addrs[0], -1);
        chk_eq("R2", "flags", {done, err_status, err_timeout}, 3'b001);
        chk_eq("R2", "fail_cmd and status", {fail_cmd, fail_status}, 0);
        chk_eq("R2", "writes", log_n, 0);
        // R2: mailbox becomes ready late at start
        prep(15, 1'b0, 0, 2, 40);
        run(addrs[1], -1);
        chk_eq("R2", "late ready done", {done, err_status, err_timeout}, 3'b100);
        chk_eq("R2", "early writes", early_wr, 0);
        check_log("R2", addrs[1], 8);

        // R5: acknowledge never arrives, each step
        for (int s = 0; s < 3; s++) begin
            prep(0, 1'b0, 0, 0, 20);
            ack_never[s] = 1'b1;
            run(addrs[2], -1);
            chk_eq("R5", "flags", {done, err_status, err_timeout}, 3'b001);
            chk_eq("R5", "fail_cmd", fail_cmd, s + 2);
            chk_eq("R5", "fail_status", fail_status, 0);
            check_log("R5", addrs[2], (s == 2) ? 8 : 3 * (s + 1));
        end

        // R11: sweep the acknowledge delay across the budget
        for (int lat = 0; lat < 3; lat += 2) begin
            seen_tmo = 1'b0;
            for (int d = 0; d <= 30; d++) begin
                prep(0, 1'b0, d, lat, 10);
                run(addrs[3], -1);
                chk_eq("R11", "exactly one outcome", {28'd0, d[3:0], 31'd0, done ^ err_timeout}, {28'd0, d[3:0], 32'd1});
                if (seen_tmo) chk_eq("R11", "monotonic timeout", done, 0);
                if (err_timeout) seen_tmo = 1'b1;
                if (d <= 2) chk_eq("R11", "short delay succeeds", done, 1);
                if (d >= 25) chk_eq("R11", "long delay times out", err_timeout, 1);
            end
        end

        // R10: failure info holds while idle, clears on start
        prep(0, 1'b0, 0, 0, 40);
        inj_stat[1] = 16'h0BAD;
        run(addrs[0], -1);
        repeat (20) @(negedge clk);
        chk_eq("R10", "held outcome", {err_status, fail_cmd, fail_status}, {1'b1, 8'h03, 16'h0BAD});
        prep(0, 1'b0, 3, 0, 40);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R10", "cleared on start", {done, err_status, err_timeout, fail_cmd, fail_status}, 0);
        while (busy) @(negedge clk);
        chk_eq("R10", "following run done", done, 1);

        // R12: start while busy is ignored
        prep(0, 1'b0, 2, 0, 40);
        run(addrs[2], 4);
        chk_eq("R12", "done", {done, err_status, err_timeout}, 3'b100);
        check_log("R12", addrs[2], 8);
        repeat (10) @(negedge clk);
        chk_eq("R12", "no further writes", log_n, 8);

        // R9: reads never overlapped
        chk_eq("R9", "overlapping requests", overlap_n, 0);
        chk(rd_n > 0, "R9", "reads seen", rd_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule